// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block shows a binary number between 0 and 99 on a pair of seven-segment digits that share a single set of segment lines. It converts the binary input into a tens digit and a units digit by arithmetic, turns each digit into a segment pattern, and uses a free-running refresh counter to light the two digits in turn. Both digits are driven through one select output. When that output is low, the right (units) digit is lit. When it is high, the left (tens) digit is lit.

The parameter `REFRESH_BITS` sets the length of the refresh counter. The display completes one full left/right cycle every 2^`REFRESH_BITS` clocks. Choose the length so that the clock frequency divided by 2^`REFRESH_BITS` falls between roughly 50 Hz and a few hundred Hz. Any input value above 99 is treated as 99. The block has no decimal point, no blanking of a leading zero and no brightness control.

Top module: `duo_seg_display`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `seg_o` = 0 and `sel_o` = 0, and the refresh counter restarts at zero.
- R2: For an input value v in 0..99, a pattern sampled while the left digit is selected shows v/10, and one sampled while the right digit is selected shows v mod 10.
- R3: `seg_o` bit 0 drives segment a, up through bit 6 for segment g, and a high bit lights its segment. The digit patterns in hex are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R4: `sel_o` is the most significant bit of the refresh counter, delayed by one register. After reset is released it stays low for 2^(`REFRESH_BITS`-1) clocks, then stays high for the same number of clocks, and this pattern repeats.
- R5: `seg_o` and `sel_o` are registered and change on the same edge. The pattern present after an edge is taken from the value present at that edge, for the digit that `sel_o` shows after that edge.
- R6: An input value above 99 is displayed as 99.
- R7: Leading zeros are kept. For a value below 10 the left digit shows the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value_i | input | VALUE_W | Binary number to display |
| seg_o | output | 7 | Segment lines, bit 0 = a ... bit 6 = g, high lights the segment |
| sel_o | output | 1 | Digit select: 0 = right/units, 1 = left/tens |

## Verification
The hardest cases to reach are an input that changes on exactly the edge where the select flips, and a clamped value shown on the left digit. Both require the input to line up with the phase of the refresh counter, which is visible only through `sel_o`. The stimulus therefore gives a new value on every clock while it sweeps 0..99 across several select periods. It also holds values above 99 for a full period, and applies a reset partway through a period so that the phase restarts.

// File: rtl/duo_seg_pkg.sv
package duo_seg_pkg;

   localparam int SEG_N   = 7;
   localparam int DIGIT_W = 4;
   localparam int MAX_VAL = 99;

   typedef logic [SEG_N-1:0]   seg_t;
   typedef logic [DIGIT_W-1:0] digit_t;

   typedef enum logic {
      SIDE_RIGHT = 1'b0,
      SIDE_LEFT  = 1'b1
   } side_e;

endpackage

// File: rtl/duo_refresh_timer.sv
module duo_refresh_timer #(
   parameter int REFRESH_BITS = 18
) (
   input  logic clk,
   input  logic rst,
   output logic phase_o
);
   logic [REFRESH_BITS-1:0] cnt_q;

   initial begin
      if (REFRESH_BITS < 2) $error("duo_refresh_timer: REFRESH_BITS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign phase_o = cnt_q[REFRESH_BITS-1];

   // R4: every full count wraps to zero
   assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '1) |=> (cnt_q == '0));

   // R1: reset restarts the count
   assert_cnt_reset_R1: assert property (@(posedge clk)
      rst |=> (cnt_q == '0));
endmodule

// File: rtl/duo_decimal_split.sv
module duo_decimal_split
   import duo_seg_pkg::*;
#(
   parameter int VALUE_W = 7
) (
   input  logic [VALUE_W-1:0] value_i,
   output digit_t             tens_o,
   output digit_t             units_o
);
   localparam int CALC_W = (VALUE_W > 7) ? VALUE_W : 7;

   initial begin
      if (VALUE_W < 7) $error("duo_decimal_split: VALUE_W must hold 99");
   end

   logic [CALC_W-1:0] wide_v;
   logic [CALC_W-1:0] clamped_v;
   logic [CALC_W-1:0] tens_w;
   logic [CALC_W-1:0] units_w;

   always_comb begin
      wide_v    = CALC_W'(value_i);
      clamped_v = (wide_v > CALC_W'(MAX_VAL)) ? CALC_W'(MAX_VAL) : wide_v;
      tens_w    = clamped_v / CALC_W'(10);
      units_w   = clamped_v - tens_w * CALC_W'(10);
      tens_o    = digit_t'(tens_w);
      units_o   = digit_t'(units_w);
   end

   // R6: oversize inputs come out as 9 and 9
   always_comb begin
      if (wide_v > CALC_W'(MAX_VAL))
         assert_clamp_R6: assert (tens_o == 4'd9 && units_o == 4'd9);
   end
endmodule

// File: rtl/duo_glyph_rom.sv
module duo_glyph_rom
   import duo_seg_pkg::*;
(
   input  digit_t digit_i,
   output seg_t   seg_o
);
   always_comb begin
      unique case (digit_i)
         4'd0:    seg_o = 7'h3F;
         4'd1:    seg_o = 7'h06;
         4'd2:    seg_o = 7'h5B;
         4'd3:    seg_o = 7'h4F;
         4'd4:    seg_o = 7'h66;
         4'd5:    seg_o = 7'h6D;
         4'd6:    seg_o = 7'h7D;
         4'd7:    seg_o = 7'h07;
         4'd8:    seg_o = 7'h7F;
         4'd9:    seg_o = 7'h6F;
         default: seg_o = 7'h00;
      endcase
   end
endmodule

// File: rtl/duo_seg_display.sv
module duo_seg_display
   import duo_seg_pkg::*;
#(
   parameter int VALUE_W      = 7,
   parameter int REFRESH_BITS = 18
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [VALUE_W-1:0] value_i,
   output logic [6:0]         seg_o,
   output logic               sel_o
);
   localparam int DIGITS = 2;

   logic   phase_w;
   digit_t digit_w [DIGITS];
   seg_t   glyph_w [DIGITS];
   seg_t   seg_next;

   duo_refresh_timer #(.REFRESH_BITS(REFRESH_BITS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .phase_o (phase_w)
   );

   duo_decimal_split #(.VALUE_W(VALUE_W)) u_split (
      .value_i (value_i),
      .tens_o  (digit_w[SIDE_LEFT]),
      .units_o (digit_w[SIDE_RIGHT])
   );

   for (genvar gi = 0; gi < DIGITS; gi++) begin : g_glyph
      duo_glyph_rom u_rom (
         .digit_i (digit_w[gi]),
         .seg_o   (glyph_w[gi])
      );
   end

   assign seg_next = phase_w ? glyph_w[SIDE_LEFT] : glyph_w[SIDE_RIGHT];

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_o <= '0;
         sel_o <= SIDE_RIGHT;
      end else begin
         seg_o <= seg_next;
         sel_o <= phase_w;
      end
   end

   // R1: reset blanks the segments and selects the right digit
   assert_reset_out_R1: assert property (@(posedge clk)
      rst |=> (seg_o == '0 && sel_o == 1'b0));

   // R4: select follows the counter phase one edge later
   assert_sel_phase_R4: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sel_o == $past(phase_w)));

   // R3: after a normal edge some segment of a real digit is lit
   assert_glyph_lit_R3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (seg_o != '0));

   // R2: both decimal digits are in 0..9
   always_comb begin
      assert_digit_range_R2: assert (digit_w[0] <= 4'd9 && digit_w[1] <= 4'd9);
   end
endmodule

// File: tb/tb_duo_seg_display.sv
module tb_duo_seg_display;
   localparam int VW = 7;
   localparam int RB = 4;

   typedef struct {
      logic [6:0] seg;
      logic       sel;
      string      tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [VW-1:0] value_i = '0;
   logic [6:0]    seg_o;
   logic          sel_o;

   int total = 0;
   int bad   = 0;
   exp_t sb_q[$];
   logic [RB-1:0] model_cnt = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   duo_seg_display #(.VALUE_W(VW), .REFRESH_BITS(RB)) dut (
      .clk     (clk),
      .rst     (rst),
      .value_i (value_i),
      .seg_o   (seg_o),
      .sel_o   (sel_o)
   );

   function automatic logic [6:0] pattern(input int d);
      case (d)
         0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
         3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
         6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
         9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   // driver: applies one cycle of stimulus and queues what must follow the edge
   task automatic drive(input int v, input bit r, input string tag);
      exp_t e;
      int   cv;
      @(negedge clk);
      rst     = r;
      value_i = VW'(v);
      if (r) begin
         e.seg = '0; e.sel = 1'b0;
         model_cnt = '0;
      end else begin
         cv    = (v > 99) ? 99 : v;
         e.sel = model_cnt[RB-1];
         e.seg = e.sel ? pattern(cv / 10) : pattern(cv % 10);
         model_cnt = model_cnt + 1'b1;
      end
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compares each result shortly after the edge that produced it
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         total++;
         if (seg_o !== e.seg || sel_o !== e.sel) begin
            bad++;
            $display("FAIL %s: got seg=%h sel=%b expected seg=%h sel=%b",
                     e.tag, seg_o, sel_o, e.seg, e.sel);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      for (int i = 0; i < 3; i++) drive(47, 1'b1, "R1 reset");
      // R4 select half-periods, R2 split of a steady value
      for (int i = 0; i < 32; i++) drive(47, 1'b0, "R4 R2 steady 47");
      // R2 R5: new value every clock across several select flips
      for (int v = 0; v < 100; v++) drive(v, 1'b0, "R2 R5 sweep");
      // R7: single-digit values keep a leading zero on the left
      for (int i = 0; i < 16; i++) drive(7, 1'b0, "R7 leading zero");
      // R6: oversize values shown as 99
      for (int i = 0; i < 16; i++) drive(100, 1'b0, "R6 clamp 100");
      for (int i = 0; i < 16; i++) drive(127, 1'b0, "R6 clamp 127");
      // R3: each digit on each side
      for (int d = 0; d < 10; d++)
         for (int i = 0; i < 16; i++) drive(d * 11, 1'b0, "R3 glyphs");
      // R1: reset partway through a half-period restarts the phase
      for (int i = 0; i < 5; i++) drive(58, 1'b0, "R4 pre-reset");
      drive(58, 1'b1, "R1 mid reset");
      for (int i = 0; i < 20; i++) drive(58, 1'b0, "R4 R1 restart");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule